// File: doc/BRIEF.md
# Serial EEPROM Write Front-End

This block is the bus-facing half of a byte-addressed nonvolatile memory of 64 KiB, attached to a two-wire serial bus as a slave. It oversamples the clock and data lines with the system clock, finds START and STOP conditions, and walks a write frame. A frame is a device address byte, a high memory-address byte, a low memory-address byte, and any number of data bytes. The block acknowledges each byte it accepts by pulling the data line low during the ninth clock. Each accepted data byte goes out on a load port with its page number and in-page offset. When the STOP arrives, the program sequencer is told to start a program cycle.

The memory address is split into a page number (upper bits) and an offset (lower bits). The offset advances after every data byte and wraps inside the page, so a long burst overwrites its own earlier bytes. The sequencer reports a running program cycle on a busy input. While busy is high the block refuses its device address, so a master can poll with address bytes until it sees an acknowledge. A write-protect input is sampled once per frame, on the clock fall that ends the low-address acknowledge. If it is high at that point, the write is refused.

The load port is valid/ready. `ld_valid` rises the cycle after a byte is accepted. Page, offset and data stay stable until the cycle in which `ld_ready` is high. The block cannot stall the bus, so the sink must take each byte before the next one completes, which is at least nine bus clock periods later. Control pins (`busy_i`, `wp_i`, `prog_start`) are plain levels or pulses.

Top module: `sbus_wr_slave`

## Requirements
- R1: A START (data falling while the clock is high) opens a frame. A device byte whose upper seven bits equal the `DEV_ADDR` parameter and whose bit 0 is 0 (write) is acknowledged.
- R2: The block drives the data line low only during an acknowledge. It pulls low after the clock fall that follows the eighth bit and releases after the next clock fall. It never drives while the master sends bits.
- R3: A device byte with a different address is not acknowledged. The block then ignores the bus, and produces no loads and no program start, until the next START.
- R4: Both memory address bytes are acknowledged, high byte first. Address bits 15..7 form the 9-bit page and bits 6..0 form the 7-bit offset of the first data byte.
- R5: Each data byte is acknowledged and presented on the load port with the current page and offset. The offset then increments by one.
- R6: After offset 127 the next byte goes to offset 0 of the same page, and the page number never changes within a frame.
- R7: A STOP that ends a frame with at least one accepted data byte produces a one-cycle `prog_start` pulse.
- R8: A STOP or a repeated START that arrives before any data byte is accepted ends the frame with no load and no `prog_start`.
- R9: While `busy_i` is high, a matching device byte is not acknowledged, whether bit 0 is 0 (write) or 1 (read). Once `busy_i` is low it is acknowledged again.
- R10: `wp_i` is sampled on the clock fall that ends the low-address acknowledge. If it is high, the first data byte is not acknowledged, no load is made, and no `prog_start` follows the STOP.
- R11: A low `wp_i` at the sampling fall lets the write proceed. A change of `wp_i` after that fall has no effect on the frame.
- R12: `ld_valid` and the page, offset and data fields hold steady while `ld_ready` is low. The byte is consumed in a cycle with both `ld_valid` and `ld_ready` high.
- R13: A matching device byte with bit 0 set to 1 (read), while not busy, is acknowledged. The block then releases the bus and makes no load.
- R14: During and after reset, `sda_oe`, `ld_valid` and `prog_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| wp_i | input | 1 | Write protect, high refuses the write |
| busy_i | input | 1 | Program cycle in progress |
| ld_valid | output | 1 | Load port holds a byte |
| ld_ready | input | 1 | Sink accepts the byte this cycle |
| ld_page | output | 9 | Page number of the byte |
| ld_offset | output | 7 | Offset within the page |
| ld_data | output | 8 | Data byte |
| prog_start | output | 1 | One-cycle request to start programming |

## Verification
The bench builds the block with `DEV_ADDR` set to 7'b1010011 rather than the default. A frame aimed at the default address therefore has to be refused, which shows that matching follows the parameter and is not a fixed constant. The offset width stays at its default of seven bits. A burst of 130 bytes thus crosses the page end and returns to its start offset, which brings the wrap and overwrite order within reach. Busy polling, late write-protect changes and a stalled sink are driven through the bus and port pins alone.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_DAT
  } phase_t;
endpackage

// File: rtl/sbw_line_cond.sv
module sbw_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  // idle bus reads high, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  // R1
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det, scl_rise, scl_fall}));
endmodule

// File: rtl/sbw_frame_ctl.sv
module sbw_frame_ctl
  import sbw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              sda_oe,
  output logic              addr_ld,
  output logic [ADDR_W-1:0] addr_q,
  output logic              data_acc,
  output logic [BYTE_W-1:0] data_q,
  output logic              prog_start
);
  phase_t            phase, nxt;
  logic [2:0]        cnt;
  logic [BYTE_W-2:0] sh;
  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] nb;
  logic              ack_arm, ack_slot, armed, wp_lat;

  assign nb = {sh, sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      nxt        <= PH_IDLE;
      cnt        <= '0;
      sh         <= '0;
      hi_q       <= '0;
      ack_arm    <= 1'b0;
      ack_slot   <= 1'b0;
      armed      <= 1'b0;
      wp_lat     <= 1'b0;
      sda_oe     <= 1'b0;
      addr_ld    <= 1'b0;
      addr_q     <= '0;
      data_acc   <= 1'b0;
      data_q     <= '0;
      prog_start <= 1'b0;
    end else begin
      addr_ld    <= 1'b0;
      data_acc   <= 1'b0;
      prog_start <= 1'b0;
      if (start_det) begin
        phase    <= PH_DEV;
        cnt      <= '0;
        ack_arm  <= 1'b0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
        armed    <= 1'b0;
        wp_lat   <= 1'b0;
      end else if (stop_det) begin
        phase      <= PH_IDLE;
        ack_arm    <= 1'b0;
        ack_slot   <= 1'b0;
        sda_oe     <= 1'b0;
        prog_start <= armed;
        armed      <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && !ack_slot) begin
          sh  <= nb[BYTE_W-2:0];
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            unique case (phase)
              PH_DEV: begin
                if (nb[7:1] == DEV_ADDR && !busy_i) begin
                  ack_arm <= 1'b1;
                  nxt     <= nb[0] ? PH_IDLE : PH_AHI;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_AHI: begin
                ack_arm <= 1'b1;
                hi_q    <= nb;
                nxt     <= PH_ALO;
              end
              PH_ALO: begin
                ack_arm <= 1'b1;
                addr_ld <= 1'b1;
                addr_q  <= {hi_q, nb};
                nxt     <= PH_DAT;
              end
              PH_DAT: begin
                if (!wp_lat) begin
                  ack_arm  <= 1'b1;
                  data_acc <= 1'b1;
                  data_q   <= nb;
                  armed    <= 1'b1;
                  nxt      <= PH_DAT;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              default: phase <= PH_IDLE;
            endcase
          end
        end else if (scl_fall) begin
          if (ack_arm) begin
            sda_oe   <= 1'b1;
            ack_arm  <= 1'b0;
            ack_slot <= 1'b1;
          end else if (ack_slot) begin
            sda_oe   <= 1'b0;
            ack_slot <= 1'b0;
            cnt      <= '0;
            phase    <= nxt;
            if (phase == PH_ALO) wp_lat <= wp_i;
          end
        end
      end
    end
  end

  // R2
  ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
  // R7
  prog_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(stop_det));
  // R10
  prog_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !wp_lat);
endmodule

// File: rtl/sbw_page_ptr.sv
module sbw_page_ptr
  import sbw_pkg::*;
#(
  parameter int OFF_W  = 7,
  parameter int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              data_acc,
  input  logic [BYTE_W-1:0] data_q,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [PAGE_W-1:0] ld_page,
  output logic [OFF_W-1:0]  ld_offset,
  output logic [BYTE_W-1:0] ld_data
);
  logic [PAGE_W-1:0] page_r;
  logic [OFF_W-1:0]  off_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_r    <= '0;
      off_r     <= '0;
      ld_valid  <= 1'b0;
      ld_page   <= '0;
      ld_offset <= '0;
      ld_data   <= '0;
    end else begin
      if (addr_ld) begin
        page_r <= addr_q[ADDR_W-1:OFF_W];
        off_r  <= addr_q[OFF_W-1:0];
      end
      if (data_acc) begin
        ld_valid  <= 1'b1;
        ld_page   <= page_r;
        ld_offset <= off_r;
        ld_data   <= data_q;
        off_r     <= off_r + 1'b1;
      end else if (ld_ready) begin
        ld_valid <= 1'b0;
      end
    end
  end

  // R5
  acc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> ld_valid);
  // R12
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready && !data_acc) |=>
      (ld_valid && $stable(ld_data) && $stable(ld_offset) && $stable(ld_page)));
  // R6
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && ld_valid && !$past(addr_ld)) |=> $stable(ld_page));
endmodule

// File: rtl/sbus_wr_slave.sv
module sbus_wr_slave
  import sbw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         OFF_W       = 7,
  parameter int         SYNC_STAGES = 2,
  localparam int        PAGE_W      = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [PAGE_W-1:0] ld_page,
  output logic [OFF_W-1:0]  ld_offset,
  output logic [BYTE_W-1:0] ld_data,
  output logic              prog_start
);
  logic              scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic              addr_ld, data_acc;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;

  sbw_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det)
  );

  sbw_frame_ctl #(.DEV_ADDR(DEV_ADDR)) u_ctl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .wp_i(wp_i), .busy_i(busy_i), .sda_oe(sda_oe),
    .addr_ld(addr_ld), .addr_q(addr_q), .data_acc(data_acc),
    .data_q(data_q), .prog_start(prog_start)
  );

  sbw_page_ptr #(.OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_q(addr_q),
    .data_acc(data_acc), .data_q(data_q), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_page(ld_page), .ld_offset(ld_offset),
    .ld_data(ld_data)
  );

  // R14
  idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!sda_oe && !ld_valid && !prog_start));
endmodule

// File: tb/test_sbus_wr_slave.sv
module test_sbus_wr_slave;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'b1010011;
  localparam logic [7:0] DW  = {DEV, 1'b0};
  localparam logic [7:0] DR  = {DEV, 1'b1};

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1, wp = 0, busy = 0, ld_ready = 1;
  logic sda_oe, ld_valid, prog_start, sda_w;
  logic [8:0] ld_page;
  logic [6:0] ld_offset;
  logic [7:0] ld_data;

  int total = 0, bad = 0, nrec = 0, nprog = 0;
  int rec_page [0:255];
  int rec_off  [0:255];
  int rec_data [0:255];

  always #5 clk = ~clk;
  assign sda_w = sda_oe ? 1'b0 : m_sda;

  sbus_wr_slave #(.DEV_ADDR(DEV)) i_sbus_wr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_w), .sda_oe(sda_oe),
    .wp_i(wp), .busy_i(busy), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_page(ld_page), .ld_offset(ld_offset), .ld_data(ld_data),
    .prog_start(prog_start)
  );

  always @(negedge clk) begin
    if (ld_valid && ld_ready && nrec < 256) begin
      rec_page[nrec] = int'(ld_page);
      rec_off[nrec]  = int'(ld_offset);
      rec_data[nrec] = int'(ld_data);
      nrec++;
    end
    if (prog_start) nprog++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; wq(1); m_scl = 1; wq(1); m_sda = 0; wq(1); m_scl = 0; wq(1);
  endtask

  task automatic bus_stop();
    m_sda = 0; wq(1); m_scl = 1; wq(1); m_sda = 1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit quiet;
    quiet = 1;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(1); m_scl = 1; wq(1);
      if (sda_oe) quiet = 0;
      wq(1); m_scl = 0; wq(1);
    end
    m_sda = 1; wq(1); m_scl = 1; wq(1);
    acked = (sda_w == 1'b0);
    wq(1); m_scl = 0; wq(1);
    chk(quiet, "R2 no drive during master bits", int'(!quiet), 0);
  endtask

  task automatic clear_rec();
    nrec = 0; nprog = 0;
  endtask

  task automatic t_reset();
    chk(!sda_oe && !ld_valid && !prog_start, "R14 reset outputs",
        int'({sda_oe, ld_valid, prog_start}), 0);
  endtask

  task automatic t_single();
    bit a0, a1, a2, a3;
    clear_rec();
    bus_start();
    send_byte(DW, a0); send_byte(8'h12, a1); send_byte(8'h34, a2); send_byte(8'hA5, a3);
    bus_stop();
    wq(1);
    chk(a0, "R1 device ack", int'(a0), 1);
    chk(a1 && a2, "R4 address acks", int'({a1, a2}), 3);
    chk(a3, "R5 data ack", int'(a3), 1);
    chk(nrec == 1, "R5 load count", nrec, 1);
    chk(rec_page[0] == 'h1234 >> 7, "R4 page", rec_page[0], 'h1234 >> 7);
    chk(rec_off[0] == ('h1234 & 127), "R4 offset", rec_off[0], 'h1234 & 127);
    chk(rec_data[0] == 'hA5, "R5 data", rec_data[0], 'hA5);
    chk(nprog == 1, "R7 program start", nprog, 1);
    chk(!sda_oe, "R2 released after stop", int'(sda_oe), 0);
  endtask

  task automatic t_burst(input int addr, input int n);
    bit a, all_ack, ok;
    clear_rec();
    all_ack = 1;
    bus_start();
    send_byte(DW, a); send_byte(8'(addr >> 8), a); send_byte(8'(addr), a);
    for (int i = 0; i < n; i++) begin
      send_byte(8'(i * 7 + 3), a);
      all_ack &= a;
    end
    bus_stop();
    wq(1);
    chk(all_ack, "R5 burst acks", int'(all_ack), 1);
    chk(nrec == n, "R5 burst loads", nrec, n);
    ok = 1;
    for (int i = 0; i < n && i < 256; i++) begin
      if (rec_off[i] != ((addr + i) & 127)) ok = 0;
      if (rec_page[i] != (addr >> 7)) ok = 0;
      if (rec_data[i] != ((i * 7 + 3) & 255)) ok = 0;
    end
    chk(ok, "R6 offset wrap within page", int'(ok), 1);
    if (n > 128)
      chk(rec_off[128] == rec_off[0], "R6 byte 128 overwrites start",
          rec_off[128], rec_off[0]);
    chk(nprog == 1, "R7 program after burst", nprog, 1);
  endtask

  task automatic t_mismatch();
    bit a0, a1;
    clear_rec();
    bus_start();
    send_byte(8'hA0, a0); send_byte(8'h00, a1); send_byte(8'h00, a1); send_byte(8'h55, a1);
    bus_stop();
    wq(1);
    chk(!a0 && !a1, "R3 no ack on mismatch", int'({a0, a1}), 0);
    chk(nrec == 0 && nprog == 0, "R3 no load or program", nrec + nprog, 0);
  endtask

  task automatic t_busy();
    bit aw, ar, a2;
    clear_rec();
    busy = 1;
    bus_start(); send_byte(DW, aw); bus_stop();
    bus_start(); send_byte(DR, ar); bus_stop();
    busy = 0;
    bus_start(); send_byte(DW, a2); bus_stop();
    chk(!aw, "R9 busy write nack", int'(aw), 0);
    chk(!ar, "R9 busy read nack", int'(ar), 0);
    chk(a2, "R9 ack after busy clears", int'(a2), 1);
    chk(nprog == 0, "R8 no program without data", nprog, 0);
  endtask

  task automatic t_read();
    bit a;
    clear_rec();
    bus_start(); send_byte(DR, a);
    chk(a, "R13 read address ack", int'(a), 1);
    wq(1);
    chk(!sda_oe, "R13 bus released", int'(sda_oe), 0);
    bus_stop(); wq(1);
    chk(nrec == 0 && nprog == 0, "R13 no load", nrec + nprog, 0);
  endtask

  task automatic t_abort();
    bit a;
    clear_rec();
    bus_start(); send_byte(DW, a); send_byte(8'h01, a); bus_stop();
    bus_start(); send_byte(DW, a); send_byte(8'h01, a); send_byte(8'h02, a);
    bus_start(); bus_stop();
    wq(1);
    chk(nrec == 0 && nprog == 0, "R8 early stop or restart", nrec + nprog, 0);
  endtask

  task automatic t_wp_high();
    bit a, ad;
    clear_rec();
    wp = 1;
    bus_start(); send_byte(DW, a); send_byte(8'h00, a); send_byte(8'h10, a);
    send_byte(8'h77, ad); bus_stop();
    wp = 0; wq(1);
    chk(!ad, "R10 protected data nack", int'(ad), 0);
    chk(nrec == 0 && nprog == 0, "R10 no load or program", nrec + nprog, 0);
  endtask

  task automatic t_wp_late();
    bit a, ad;
    clear_rec();
    bus_start(); send_byte(DW, a); send_byte(8'h00, a); send_byte(8'h20, a);
    fork
      send_byte(8'h3C, ad);
      begin wq(2); wp = 1; end
    join
    bus_stop();
    wp = 0; wq(1);
    chk(ad, "R11 late protect ignored", int'(ad), 1);
    chk(nrec == 1 && nprog == 1, "R11 write proceeds", nrec * 2 + nprog, 3);
  endtask

  task automatic t_stall();
    bit a;
    clear_rec();
    ld_ready = 0;
    bus_start(); send_byte(DW, a); send_byte(8'h01, a); send_byte(8'h80, a);
    send_byte(8'hC3, a); bus_stop();
    wq(2);
    chk(ld_valid && ld_data == 8'hC3 && ld_offset == 7'd0 && ld_page == 9'd3,
        "R12 held while stalled", int'(ld_data), 'hC3);
    chk(nrec == 0, "R12 not consumed", nrec, 0);
    ld_ready = 1;
    wq(1);
    chk(nrec == 1 && !ld_valid, "R12 consumed on ready", nrec, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_burst('h03FE, 4);
    t_burst('h4A05, 130);
    t_mismatch();
    t_busy();
    t_read();
    t_abort();
    t_wp_high();
    t_wp_late();
    t_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule